// File: doc/BRIEF.md
# Duplex Grid Dimming Timing Generator

This block times a two-grid multiplexed vacuum-fluorescent display. It divides the system clock into bit times of a fixed number of clocks. It counts a frame of 4096 bit times, split into two phases of 2048 bit times each. The first grid is driven in the first phase and the second grid in the second. In each phase, the grid is lit from the start of the phase for an on-count of bit times. A segment enable runs a few bit times longer than the grid, so the segments switch off inside the grid's dark gap.

The on-count depends on a day/night input. In day mode it is the full value of 2032. In night mode it comes from one of two sources. One is an 11-bit digital level, clamped at 2032. The other is a 6-bit analog step number, mapped through a nonlinear curve that tops out at 256. The on-count is captured only at the end of a frame, so a change made in mid-frame never cuts a pulse short. A test input lights every segment and pulls both grid outputs low. A monitor output shows the logical grid pulse.

Top module: `duplex_dim_timer`

## Requirements
- R1: One bit time is OSC_PER_BIT (default 4) clocks. A frame is 4096 bit times. The first grid may be active only in bit times 0..2047 and the second grid only in bit times 2048..4095, so at most one grid is active at a time.
- R2: With on-count N, a grid is logically active at phase positions 0..N-1 of its own phase, where phase position = bit time mod 2048. Both phases use the same N.
- R3: With N>0, the segment enable is high at phase positions 0..N+5 of each phase. With N=0 it stays low. It is high whenever a grid is active.
- R4: When night_i=0, N=2032 regardless of the source select and the level inputs.
- R5: When night_i=1 and src_digital_i=1, N=min(dig_level_i, 2032). Level 0 gives no pulse, level 1 gives one bit time, and levels 2032..2047 all give 2032.
- R6: When night_i=1 and src_digital_i=0, N follows the step s on ana_step_i:
  - s=0 gives 0.
  - s=1..12 gives s+12.
  - s=13..24 rises by 2 per step, up to 48.
  - s=25..36 gives 52 then rises by 4 per step, up to 96.
  - s=37..48 gives 104 then rises by 8 per step, up to 192.
  - s=49..52 rises by 16 per step, up to 256.
  - s>52 gives 256.
- R7: N is captured from the inputs on the clock edge that ends a frame. Input changes during a frame have no effect on that frame. After reset, the first frame uses N=0.
- R8: grid1_n_o and grid2_n_o are active-low: each is 0 exactly when its grid is logically active.
- R9: test_i=1 forces seg_en_o=1 and both grid outputs to 0 at once, with no effect on pwm_o.
- R10: pwm_o is 1 exactly when either grid is logically active.
- R11: While reset is asserted, grid1_n_o=1, grid2_n_o=1, seg_en_o=0 and pwm_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| night_i | input | 1 | 1 selects night (dimmed) mode, 0 selects day (full) mode |
| src_digital_i | input | 1 | 1 selects the digital level, 0 selects the analog step |
| dig_level_i | input | 11 | Digital dimming level |
| ana_step_i | input | 6 | Analog step number from the external comparator |
| test_i | input | 1 | Forces all segments on and both grid outputs low |
| grid1_n_o | output | 1 | First grid drive, active low |
| grid2_n_o | output | 1 | Second grid drive, active low |
| seg_en_o | output | 1 | Segment enable |
| pwm_o | output | 1 | Monitor of the logical grid pulse |

## Verification
Whole frames are compared bit time by bit time against a model.

- The sequence first covers the dark frame after reset, a day frame whose digital level must be ignored, and digital levels 1 and 2047. These separate the day override from the clamp and from a plain pass-through of the level.
- Analog steps 63, 45 and 17 cover the top saturation, a step in the eight-per-step segment and a step in the two-per-step segment. An off-by-one in a segment boundary shifts the count.
- A source change at mid-frame, followed by a level-0 frame, shows the capture happens only at the frame boundary.
- The test frame shows the forcing acts at once on the drive pins and leaves the monitor alone.

// File: rtl/dgd_pkg.sv
package dgd_pkg;

  localparam int unsigned ANA_MAX_COUNT = 256;

  // Clamp a digital level to the longest allowed on-time.
  function automatic int unsigned dig_clamp(input int unsigned lvl, input int unsigned lim);
    return (lvl > lim) ? lim : lvl;
  endfunction

  // Piecewise map from analog step number to on-count in bit times.
  function automatic int unsigned ana_count(input int unsigned s);
    if (s == 0)       return 0;
    else if (s <= 12) return s + 12;
    else if (s <= 24) return 24 + 2 * (s - 12);
    else if (s <= 36) return 52 + 4 * (s - 25);
    else if (s <= 48) return 104 + 8 * (s - 37);
    else if (s <= 52) return 192 + 16 * (s - 48);
    else              return ANA_MAX_COUNT;
  endfunction

  // Pick the on-count from the mode inputs.
  function automatic int unsigned pick_count(input logic night, input logic src_dig,
                                             input int unsigned lvl, input int unsigned step,
                                             input int unsigned full);
    if (!night)  return full;
    if (src_dig) return dig_clamp(lvl, full);
    return ana_count(step);
  endfunction

endpackage

// File: rtl/dgd_bit_timer.sv
module dgd_bit_timer #(
  parameter int OSC_PER_BIT = 4,
  parameter int FRAME_BITS  = 4096,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int PRE_W = (OSC_PER_BIT > 1) ? $clog2(OSC_PER_BIT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] bit_pos_o,
  output logic             frame_end_o
);
  logic             tick;
  logic [POS_W-1:0] bit_q;

  generate
    if (OSC_PER_BIT > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  pre_q <= '0;
        else if (pre_q == PRE_W'(OSC_PER_BIT - 1))   pre_q <= '0;
        else                                         pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PRE_W'(OSC_PER_BIT - 1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  assign frame_end_o = tick && (bit_q == POS_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bit_q <= '0;
    else if (frame_end_o) bit_q <= '0;
    else if (tick)        bit_q <= bit_q + 1'b1;
  end

  assign bit_pos_o = bit_q;

  // R1
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(bit_pos_o));
  // R1
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> (bit_pos_o == '0));
endmodule

// File: rtl/dgd_duty_latch.sv
module dgd_duty_latch
  import dgd_pkg::*;
#(
  parameter int FULL_ON = 2032,
  parameter int DIG_W   = 11,
  parameter int STEP_W  = 6,
  parameter int CNT_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end_i,
  input  logic              night_i,
  input  logic              src_digital_i,
  input  logic [DIG_W-1:0]  dig_level_i,
  input  logic [STEP_W-1:0] ana_step_i,
  output logic [CNT_W-1:0]  on_cnt_o
);
  logic [CNT_W-1:0] next_cnt;
  logic [CNT_W-1:0] on_cnt_q;

  always_comb begin
    next_cnt = CNT_W'(pick_count(night_i, src_digital_i, int'(unsigned'(dig_level_i)),
                                 int'(unsigned'(ana_step_i)), FULL_ON));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           on_cnt_q <= '0;
    else if (frame_end_i) on_cnt_q <= next_cnt;
  end

  assign on_cnt_o = on_cnt_q;

  // R7
  cnt_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_i |=> $stable(on_cnt_o));
  // R5
  cnt_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_cnt_o <= CNT_W'(FULL_ON));
  // R6
  ana_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && night_i && !src_digital_i) |=> (on_cnt_o <= CNT_W'(ANA_MAX_COUNT)));
endmodule

// File: rtl/dgd_drive_gen.sv
module dgd_drive_gen #(
  parameter int POS_W    = 12,
  parameter int CNT_W    = 12,
  parameter int SEG_TAIL = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] bit_pos_i,
  input  logic [CNT_W-1:0] on_cnt_i,
  input  logic             test_i,
  output logic             grid1_n_o,
  output logic             grid2_n_o,
  output logic             seg_en_o,
  output logic             pwm_o
);
  logic             second_phase;
  logic [CNT_W:0]   phase_pos;
  logic [CNT_W:0]   seg_limit;
  logic             grid_act;
  logic             g1_act;
  logic             g2_act;
  logic             seg_act;

  assign second_phase = bit_pos_i[POS_W-1];
  assign phase_pos    = (CNT_W+1)'(bit_pos_i[POS_W-2:0]);
  assign seg_limit    = {1'b0, on_cnt_i} + (CNT_W+1)'(SEG_TAIL);
  assign grid_act     = phase_pos < {1'b0, on_cnt_i};
  assign g1_act       = grid_act && !second_phase;
  assign g2_act       = grid_act && second_phase;
  assign seg_act      = (on_cnt_i != '0) && (phase_pos < seg_limit);

  assign grid1_n_o = test_i ? 1'b0 : !g1_act;
  assign grid2_n_o = test_i ? 1'b0 : !g2_act;
  assign seg_en_o  = test_i | seg_act;
  assign pwm_o     = g1_act | g2_act;

  // R1
  grid_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({g1_act, g2_act}));
  // R3
  seg_covers_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g1_act || g2_act) |-> seg_act);
  // R9
  test_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_i |-> (!grid1_n_o && !grid2_n_o && seg_en_o));
endmodule

// File: rtl/duplex_dim_timer.sv
module duplex_dim_timer #(
  parameter int OSC_PER_BIT = 4,
  parameter int PHASE_BITS  = 2048,
  parameter int GUARD_BITS  = 16,
  parameter int SEG_TAIL    = 6,
  parameter int DIG_W       = 11,
  parameter int STEP_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              night_i,
  input  logic              src_digital_i,
  input  logic [DIG_W-1:0]  dig_level_i,
  input  logic [STEP_W-1:0] ana_step_i,
  input  logic              test_i,
  output logic              grid1_n_o,
  output logic              grid2_n_o,
  output logic              seg_en_o,
  output logic              pwm_o
);
  localparam int FRAME_BITS = 2 * PHASE_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int CNT_W      = $clog2(PHASE_BITS + 1);
  localparam int FULL_ON    = PHASE_BITS - GUARD_BITS;

  logic [POS_W-1:0] bit_pos;
  logic             frame_end;
  logic [CNT_W-1:0] on_cnt;

  dgd_bit_timer #(.OSC_PER_BIT(OSC_PER_BIT), .FRAME_BITS(FRAME_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_pos_o(bit_pos), .frame_end_o(frame_end));

  dgd_duty_latch #(.FULL_ON(FULL_ON), .DIG_W(DIG_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .frame_end_i(frame_end), .night_i(night_i),
    .src_digital_i(src_digital_i), .dig_level_i(dig_level_i), .ana_step_i(ana_step_i),
    .on_cnt_o(on_cnt));

  dgd_drive_gen #(.POS_W(POS_W), .CNT_W(CNT_W), .SEG_TAIL(SEG_TAIL)) u_drive (
    .clk(clk), .rst_n(rst_n), .bit_pos_i(bit_pos), .on_cnt_i(on_cnt), .test_i(test_i),
    .grid1_n_o(grid1_n_o), .grid2_n_o(grid2_n_o), .seg_en_o(seg_en_o), .pwm_o(pwm_o));

  // R8
  grid_pwm_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_i |-> (pwm_o == (!grid1_n_o || !grid2_n_o)));
endmodule

// File: tb/tb_duplex_dim_timer.sv
`timescale 1ns/1ps
module tb_duplex_dim_timer;
  localparam int OSC = 4;
  localparam int FRAME_CLK = 4096 * OSC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic night = 1'b0, src_dig = 1'b1, test = 1'b0;
  logic [10:0] dig = 11'd5;
  logic [5:0] step = 6'd0;
  logic g1n, g2n, seg, pwm;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  duplex_dim_timer dut (
    .clk(clk), .rst_n(rst_n), .night_i(night), .src_digital_i(src_dig),
    .dig_level_i(dig), .ana_step_i(step), .test_i(test),
    .grid1_n_o(g1n), .grid2_n_o(g2n), .seg_en_o(seg), .pwm_o(pwm));

  // Independent restatement of the analog curve: sum of per-step increments (R6).
  function automatic int model_ana(input int s);
    int c = 0;
    for (int k = 1; k <= s; k++) begin
      if (k == 1) c += 13;
      else if (k <= 12) c += 1;
      else if (k <= 24) c += 2;
      else if (k <= 36) c += (k == 25) ? 4 : 4;
      else if (k <= 48) c += 8;
      else if (k <= 52) c += 16;
    end
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one frame from its first clock; compares every sample to the model.
  task automatic run_frame(input string req, input int n, input bit tst,
                           input int mid_at, input bit m_night, input bit m_src, input int m_dig);
    int bad_g1 = 0, bad_g2 = 0, bad_seg = 0, bad_pwm = 0;
    for (int i = 0; i < FRAME_CLK; i++) begin
      int bt, pos;
      bit ph, act, e1n, e2n, es;
      #1;
      bt = i / OSC; ph = (bt >= 2048); pos = bt % 2048;
      act = (pos < n);
      e1n = tst ? 1'b0 : !(act && !ph);
      e2n = tst ? 1'b0 : !(act && ph);
      es  = tst ? 1'b1 : ((n > 0) && (pos < n + 6));
      if (g1n !== e1n) bad_g1++;
      if (g2n !== e2n) bad_g2++;
      if (seg !== es)  bad_seg++;
      if (pwm !== act) bad_pwm++;
      if (i == mid_at) begin night = m_night; src_dig = m_src; dig = 11'(m_dig); end
      @(negedge clk);
    end
    check({req, " R2 R8 grid1 mismatches"}, bad_g1, 0);
    check({req, " R1 R8 grid2 mismatches"}, bad_g2, 0);
    check({req, " R3 seg mismatches"}, bad_seg, 0);
    check({req, " R10 pwm mismatches"}, bad_pwm, 0);
  endtask

  // R11: outputs while reset is held
  task automatic t_reset;
    repeat (3) @(negedge clk);
    #1;
    check("R11 grid1_n in reset", g1n, 1);
    check("R11 grid2_n in reset", g2n, 1);
    check("R11 seg_en in reset", seg, 0);
    check("R11 pwm in reset", pwm, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R7: first frame dark; day mode prepared for next
  task automatic t_first_frame;
    night = 1'b0; src_dig = 1'b1; dig = 11'd5;
    run_frame("R7 first frame", 0, 0, -1, 0, 0, 0);
  endtask

  // R4: day frame ignores digital level 1 queued for the next frame
  task automatic t_day;
    night = 1'b1; src_dig = 1'b1; dig = 11'd1;
    run_frame("R4 day full", 2032, 0, -1, 0, 0, 0);
  endtask

  // R5: digital level 1
  task automatic t_dig_one;
    dig = 11'd2047;
    run_frame("R5 level 1", 1, 0, -1, 0, 0, 0);
  endtask

  // R5: digital clamp at 2047
  task automatic t_dig_clamp;
    src_dig = 1'b0; step = 6'd63;
    run_frame("R5 clamp 2047", 2032, 0, -1, 0, 0, 0);
  endtask

  // R6: analog step 63 saturates
  task automatic t_ana_top;
    step = 6'd45;
    run_frame("R6 step 63", model_ana(63), 0, -1, 0, 0, 0);
  endtask

  // R6 + R7: step 45, with a mid-frame switch to digital level 0
  task automatic t_ana_mid_change;
    step = 6'd5;
    run_frame("R6 R7 step 45", model_ana(45), 0, 8000, 1, 1, 0);
  endtask

  // R5: level 0 gives no pulse; analog step 17 queued
  task automatic t_dig_zero;
    src_dig = 1'b0; step = 6'd17;
    run_frame("R5 level 0", 0, 0, -1, 1, 0, 0);
  endtask

  // R9: test forcing with analog step 17 running
  task automatic t_test;
    test = 1'b1;
    run_frame("R9 test", model_ana(17), 1, -1, 1, 0, 0);
    test = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_first_frame();
    t_day();
    t_dig_one();
    t_dig_clamp();
    t_ana_top();
    t_ana_mid_change();
    t_dig_zero();
    t_test();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule